// File: doc/BRIEF.md
# Deep Power-Down Control Register

This block is a single memory-mapped control word that governs the power state of a small microcontroller. Three bits decide whether the main core is powered, whether SRAM keeps its supply (and contents) while the core is switched off, and whether the 32 kHz oscillator runs. Software enters deep power-down by writing the core-power bit to zero. The block drives one enable output per power domain and a flag that shows the deep power-down state.

Once the core is off there is no core clock to rely on. Any wake source then forces all three bits back to one at once, with no clock edge needed. The wake sources are the power-on-reset signal, an alarm-match input from the real-time clock, and a low level on any external interrupt pin. The pin wake works whatever the pins are configured for elsewhere. While the core is powered, the interrupt pins pass through a two-flop synchroniser before they act. A synchronous reset also restores full power.

Top module: `pwr_ctl_reg`

## Requirements
- R1: A write with `bus_we` high and `bus_addr` equal to `REG_ADDR` loads `bus_wdata[2:0]` into the control bits at that clock edge. Bit 0 is core power, bit 1 is SRAM retention and bit 2 is oscillator enable.
- R2: When control bit 0 is 0, `core_pwr_en` is low and `in_deep_pd` is high. When bit 0 is 1, `core_pwr_en` is high and `in_deep_pd` is low.
- R3: `sram_pwr_en` is high whenever control bit 0 is 1. While bit 0 is 0, it equals control bit 1.
- R4: `osc_en` equals control bit 2.
- R5: A high `rst` at a clock edge sets all three control bits to 1. This holds even when a bus write is presented at the same edge.
- R6: A high `por_wake` or `rtc_alarm` sets all three control bits to 1 at once, without waiting for a clock edge.
- R7: While control bit 0 is 0, a low level on any bit of `eint_n` sets all three control bits to 1 without any clock edge.
- R8: While control bit 0 is 1, a low level on `eint_n` sets all three control bits to 1 on the third rising clock edge after the pin goes low. The control bits are unchanged after the first two of those edges.
- R9: When a wake event and a bus write to `REG_ADDR` fall on the same clock edge, the wake event wins and all three control bits become 1.
- R10: `bus_rdata` is registered. At each clock edge it takes `{29'b0, control bits}` if `bus_addr` equals `REG_ADDR`, and zero for any other address. Bits 31:3 of a write are discarded and always read as 0.
- R11: A write to any address other than `REG_ADDR` leaves the control bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset; also a wake source |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | DATA_W (32) | Register bus write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| eint_n | input | NUM_EINT (3) | Active-low external interrupt pins |
| rtc_alarm | input | 1 | Alarm-match wake from the real-time clock |
| por_wake | input | 1 | Power-on-reset wake |
| core_pwr_en | output | 1 | Main core power switch enable |
| sram_pwr_en | output | 1 | SRAM supply enable |
| osc_en | output | 1 | 32 kHz oscillator enable |
| in_deep_pd | output | 1 | High while in deep power-down |

## Verification
The hardest case is a wake with no clock edge at all. The bench reaches it by stopping its own clock after it has put the block into deep power-down. It then raises the alarm input, or pulls one interrupt pin low, and checks that the enables come back before any edge arrives. The synchronised pin path is reached by holding a pin low while the core is powered and counting edges. The same-edge conflict is reached by timing a write to land on the exact edge where the synchronised pin first acts.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int NUM_CTRL = 3;
  localparam int BIT_CORE = 0;
  localparam int BIT_SRAM = 1;
  localparam int BIT_OSC  = 2;
  typedef logic [NUM_CTRL-1:0] ctrl_t;
  localparam ctrl_t CTRL_ALL_ON = '1;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] pin_n_sync
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n[g]};
      end
      assign pin_n_sync[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int N = 3
) (
  input  logic         rst,
  input  logic         por_wake,
  input  logic         rtc_alarm,
  input  logic [N-1:0] eint_raw_n,
  input  logic [N-1:0] eint_sync_n,
  input  logic         deep,
  output logic         wake_async,
  output logic         wake_sync
);
  logic raw_low, sync_low;
  assign raw_low  = ~&eint_raw_n;
  assign sync_low = ~&eint_sync_n;
  // Without a core clock, a pin level must act directly
  assign wake_async = por_wake | rtc_alarm | (deep & raw_low);
  assign wake_sync  = rst | sync_low;
endmodule

// File: rtl/pwr_ctl_bits.sv
module pwr_ctl_bits
  import pwr_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wake_async,
  input  logic  wake_sync,
  input  logic  wr_en,
  input  ctrl_t wr_bits,
  output ctrl_t ctrl
);
  always_ff @(posedge clk or posedge wake_async) begin
    if (wake_async)     ctrl <= CTRL_ALL_ON;
    else if (wake_sync) ctrl <= CTRL_ALL_ON;
    else if (wr_en)     ctrl <= wr_bits;
  end

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wake_sync && !wake_async) |=> (ctrl == $past(wr_bits))); // R1
  AST_WAKE_WINS: assert property (@(posedge clk) disable iff (rst)
    wake_sync |=> (ctrl == CTRL_ALL_ON)); // R9
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
#(
  parameter int             ADDR_W      = 8,
  parameter int             DATA_W      = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40,
  parameter int             NUM_EINT    = 3,
  parameter int             SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_EINT-1:0] eint_n,
  input  logic                rtc_alarm,
  input  logic                por_wake,
  output logic                core_pwr_en,
  output logic                sram_pwr_en,
  output logic                osc_en,
  output logic                in_deep_pd
);
  localparam int PAD_W = DATA_W - NUM_CTRL;

  ctrl_t               ctrl;
  logic [NUM_EINT-1:0] eint_sync_n;
  logic                wake_async, wake_sync, hit, wr_hit;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_we & hit;

  pwr_pin_sync #(.N(NUM_EINT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(eint_n), .pin_n_sync(eint_sync_n)
  );

  pwr_wake_detect #(.N(NUM_EINT)) u_wake (
    .rst(rst), .por_wake(por_wake), .rtc_alarm(rtc_alarm),
    .eint_raw_n(eint_n), .eint_sync_n(eint_sync_n),
    .deep(~ctrl[BIT_CORE]), .wake_async(wake_async), .wake_sync(wake_sync)
  );

  pwr_ctl_bits u_bits (
    .clk(clk), .rst(rst), .wake_async(wake_async), .wake_sync(wake_sync),
    .wr_en(wr_hit), .wr_bits(bus_wdata[NUM_CTRL-1:0]), .ctrl(ctrl)
  );

  always_ff @(posedge clk) begin
    if (rst)      bus_rdata <= '0;
    else if (hit) bus_rdata <= {{PAD_W{1'b0}}, ctrl};
    else          bus_rdata <= '0;
  end

  assign core_pwr_en = ctrl[BIT_CORE];
  assign sram_pwr_en = ctrl[BIT_CORE] | ctrl[BIT_SRAM];
  assign osc_en      = ctrl[BIT_OSC];
  assign in_deep_pd  = ~ctrl[BIT_CORE];

  AST_CORE_OFF_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_pwr_en) |-> $past(wr_hit)); // R2
  AST_WAKE_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    ($rose(core_pwr_en) && !$past(wr_hit)) |-> (osc_en && sram_pwr_en)); // R6
  AST_SRAM_DROP_DEEP: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_pwr_en) |-> in_deep_pd); // R3
endmodule

// File: tb/pwr_ctl_reg_bench.sv
`timescale 1ns/1ps
module pwr_ctl_reg_bench;
  localparam logic [7:0] REG = 8'h40;
  localparam logic [7:0] OTHER = 8'h44;

  typedef struct {
    string       tag;
    logic [3:0]  exp_o;
    bit          chk_rd;
    logic [31:0] exp_rd;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  logic clk = 0;
  bit clk_run = 1;
  logic rst = 1, bus_we = 0, rtc_alarm = 0, por_wake = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0] eint_n = 3'b111;
  logic [31:0] bus_rdata;
  logic core_pwr_en, sram_pwr_en, osc_en, in_deep_pd;

  always #2 if (clk_run) clk = ~clk;

  pwr_ctl_reg u_pwr_ctl_reg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eint_n(eint_n),
    .rtc_alarm(rtc_alarm), .por_wake(por_wake), .core_pwr_en(core_pwr_en),
    .sram_pwr_en(sram_pwr_en), .osc_en(osc_en), .in_deep_pd(in_deep_pd)
  );

  // Expected outputs {core, sram, osc, deep} from control bits
  function automatic logic [3:0] outs(input logic [2:0] b);
    return {b[0], b[0] | b[1], b[2], ~b[0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_bits(input string tag, input logic [2:0] b);
    item_t it;
    it.tag = tag; it.exp_o = outs(b); it.chk_rd = 0; it.exp_rd = '0;
    q.push_back(it);
    #1;
  endtask

  task automatic expect_read(input string tag, input logic [7:0] a,
                             input logic [2:0] b, input logic [31:0] rd);
    item_t it;
    bus_addr = a; bus_we = 0;
    tick(1);
    it.tag = tag; it.exp_o = outs(b); it.chk_rd = 1; it.exp_rd = rd;
    q.push_back(it);
    #1;
  endtask

  task automatic write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    tick(1);
    bus_we = 0;
    tick(1);
  endtask

  // Monitor: pops each expected item and compares against the ports
  initial begin
    item_t it;
    logic [3:0] act;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      act = {core_pwr_en, sram_pwr_en, osc_en, in_deep_pd};
      if (act !== it.exp_o) begin
        errors++;
        $display("FAIL %s outs actual=%b expected=%b", it.tag, act, it.exp_o);
      end else if (it.chk_rd && bus_rdata !== it.exp_rd) begin
        errors++;
        $display("FAIL %s rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp_rd);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    expect_bits("R5 reset all on", 3'b111);
    rst = 0;
    expect_read("R10 read after reset", REG, 3'b111, 32'h7);

    write(REG, 32'hFFFF_FFF9);
    expect_bits("R1 R4 write 001 osc off", 3'b001);
    expect_read("R10 reserved bits dropped", REG, 3'b001, 32'h1);

    write(OTHER, 32'h0);
    expect_bits("R11 other address ignored", 3'b001);
    expect_read("R10 other address reads zero", OTHER, 3'b001, 32'h0);

    write(REG, 32'h4);
    expect_bits("R2 R3 deep, sram off, osc on", 3'b100);

    clk_run = 0;
    rtc_alarm = 1;
    #1;
    expect_bits("R6 rtc alarm wakes without clock", 3'b111);
    rtc_alarm = 0;
    clk_run = 1;

    write(REG, 32'h2);
    expect_bits("R3 deep with sram retained", 3'b010);

    clk_run = 0;
    eint_n = 3'b101;
    #1;
    expect_bits("R7 pin low wakes without clock", 3'b111);
    eint_n = 3'b111;
    clk_run = 1;

    write(REG, 32'h0);
    expect_bits("R2 R3 deep all off", 3'b000);
    por_wake = 1;
    #1;
    expect_bits("R6 por wake", 3'b111);
    write(REG, 32'h0);
    expect_bits("R9 write loses to held por", 3'b111);
    por_wake = 0;
    tick(1);

    write(REG, 32'h1);
    expect_bits("R1 write 001", 3'b001);
    eint_n = 3'b110;
    tick(2);
    expect_bits("R8 unchanged after two edges", 3'b001);
    tick(1);
    expect_bits("R8 synced pin wake", 3'b111);
    eint_n = 3'b111;
    tick(3);

    write(REG, 32'h1);
    expect_bits("R1 write 001 again", 3'b001);
    eint_n = 3'b011;
    tick(2);
    write(REG, 32'h1);
    expect_bits("R9 synced wake beats same-edge write", 3'b111);
    eint_n = 3'b111;
    tick(3);

    write(REG, 32'h2);
    bus_addr = REG; bus_wdata = 32'h0; bus_we = 1; rst = 1;
    tick(1);
    expect_bits("R5 reset beats same-edge write", 3'b111);
    rst = 0; bus_we = 0;
    tick(1);
    expect_read("R10 final read", REG, 3'b111, 32'h7);

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule